// File: doc/BRIEF.md
# Double-Buffered Serial DAC Register

This block is the digital front end of a serial digital-to-analog converter, written so that a testbench can use it as a device model or a checker. A serial word is shifted into an input register on rising serial-clock edges while the active-low select line is low. The output code is held in a separate register, so a new word can be preloaded while the present output stays put. The output register takes the preloaded word only on a rising edge of the active-low load line, and only while the active-low clear line is high.

All serial-side inputs are asynchronous to a fast system clock. Each passes through a two-flop synchroniser before edge detection. Holding clear low forces the output to zero scale. Next to the code, the block gives a millivolt value at one millivolt per code step, so the range is 0 to 4095 mV. It also gives a one-cycle flag each time the output code changes.

Top module: `dac_frontend`

## Requirements
- R1: After reset the output code, the millivolt value and the update flag are all zero.
- R2: Clocking serial bits into the input register, with clear and load idle, leaves the output code unchanged.
- R3: A rising edge on loadN with clrN high copies the input register to the output code. Bits enter MSB first, one per rising serClk edge, so the first bit received ends up as bit 11.
- R4: Rising serClk edges that occur while csN is high shift nothing. A later load then reproduces the earlier word.
- R5: When more than 12 bits are clocked in, the last 12 bits received are kept.
- R6: While clrN is low the output code is zero, and a rising edge on loadN has no effect. The input register is not cleared, so a load after clrN returns high transfers the word shifted in earlier.
- R7: The millivolt output equals the code times one: 0x7FF gives 2047 and 0xFFF gives 4095.
- R8: The update flag is high for exactly one system cycle for each change of the output code. A load that rewrites the same value raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rstN | input | 1 | Active-low asynchronous reset |
| serClk | input | 1 | Serial clock, idles high; data sampled on its rising edge |
| serData | input | 1 | Serial data, MSB first |
| csN | input | 1 | Active-low chip select gating the shift |
| loadN | input | 1 | Active-low load; transfer on its rising edge |
| clrN | input | 1 | Active-low clear to zero scale |
| code | output | 12 | Present output register code |
| millivolts | output | 12 | Output level in millivolts |
| updated | output | 1 | One-cycle pulse on each output change |

## Verification
Words are shifted and loaded in several shapes. Alternating bit patterns (0xA5C) show that bit order and alignment are correct. 0x7FF and 0xFFF sit on the mid-scale and full-scale millivolt boundaries. A 16-bit frame shows that the oldest bits are dropped. Serial clock edges sent with select high, and loads made while clear is asserted, show that those lines gate the shift and the transfer. Counting update pulses between actions tells a real change from a rewrite of the same value.

// File: rtl/dac_pkg.sv
package dac_pkg;
  // strobes passed from the control path to the datapath
  typedef struct packed {
    logic shift;   // take one serial bit
    logic bitVal;  // the bit to take
    logic load;    // move input register to output register
    logic clr;     // hold output at zero scale
  } strobe_t;
endpackage

// File: rtl/dac_sync.sv
module dac_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[s] <= RESET_VAL;
        else if (s == 0) stage[s] <= din;
        else stage[s] <= stage[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/dac_ctrl.sv
module dac_ctrl
  import dac_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    serClk,
  input  logic    serData,
  input  logic    csN,
  input  logic    loadN,
  input  logic    clrN,
  output strobe_t strb
);
  localparam int NUM_IN = 5;
  // bit order: 0 serClk, 1 serData, 2 csN, 3 loadN, 4 clrN
  localparam logic [NUM_IN-1:0] IDLE_VAL = 5'b11101;

  logic [NUM_IN-1:0] rawIn;
  logic [NUM_IN-1:0] syncd;
  logic clkPrev;
  logic loadPrev;

  assign rawIn = {clrN, loadN, csN, serData, serClk};

  dac_sync #(
    .WIDTH(NUM_IN),
    .STAGES(SYNC_STAGES),
    .RESET_VAL(IDLE_VAL)
  ) i_sync (
    .clk(clk),
    .rstN(rstN),
    .din(rawIn),
    .dout(syncd)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPrev  <= 1'b1;
      loadPrev <= 1'b1;
    end else begin
      clkPrev  <= syncd[0];
      loadPrev <= syncd[3];
    end
  end

  always_comb begin
    strb.shift  = syncd[0] & ~clkPrev & ~syncd[2];
    strb.bitVal = syncd[1];
    strb.load   = syncd[3] & ~loadPrev & syncd[4];
    strb.clr    = ~syncd[4];
  end

  // R4
  shift_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.shift |=> !strb.shift);

  // R3
  load_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> !strb.load);
endmodule

// File: rtl/dac_datapath.sv
module dac_datapath
  import dac_pkg::*;
#(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  output logic [CODE_W-1:0] code,
  output logic              updated
);
  logic [CODE_W-1:0] shiftReg;
  logic [CODE_W-1:0] outReg;
  logic [CODE_W-1:0] nextOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (strb.shift) shiftReg <= {shiftReg[CODE_W-2:0], strb.bitVal};
  end

  always_comb begin
    nextOut = outReg;
    if (strb.clr) nextOut = '0;
    else if (strb.load) nextOut = shiftReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg  <= '0;
      updated <= 1'b0;
    end else begin
      outReg  <= nextOut;
      updated <= (nextOut != outReg);
    end
  end

  assign code = outReg;

  // R6
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clr |=> outReg == '0);

  // R2
  hold_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.clr) |=> $stable(outReg));

  // R3
  load_xfer_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> outReg == $past(shiftReg));

  // R8
  upd_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(outReg) |-> updated);
endmodule

// File: rtl/dac_frontend.sv
module dac_frontend #(
  parameter int CODE_W = 12,
  parameter int MV_PER_LSB = 1,
  parameter int SYNC_STAGES = 2,
  localparam int MV_W = $clog2(((2 ** CODE_W) - 1) * MV_PER_LSB + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              serData,
  input  logic              csN,
  input  logic              loadN,
  input  logic              clrN,
  output logic [CODE_W-1:0] code,
  output logic [MV_W-1:0]   millivolts,
  output logic              updated
);
  dac_pkg::strobe_t strb;

  dac_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk),
    .rstN(rstN),
    .serClk(serClk),
    .serData(serData),
    .csN(csN),
    .loadN(loadN),
    .clrN(clrN),
    .strb(strb)
  );

  dac_datapath #(.CODE_W(CODE_W)) i_dp (
    .clk(clk),
    .rstN(rstN),
    .strb(strb),
    .code(code),
    .updated(updated)
  );

  assign millivolts = MV_W'(code * MV_PER_LSB);

  // R7
  mv_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    updated |-> millivolts == MV_W'(code * MV_PER_LSB));
endmodule

// File: tb/test_dac_frontend.sv
module test_dac_frontend;
  localparam time CLK_PERIOD = 10ns;
  localparam int HALF = 6;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b1;
  logic serData = 1'b0;
  logic csN = 1'b1;
  logic loadN = 1'b1;
  logic clrN = 1'b1;
  logic [11:0] code;
  logic [11:0] millivolts;
  logic updated;

  int checks = 0;
  int fails = 0;
  int updCount = 0;
  int runLen = 0;
  int maxRun = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_frontend i_dac_frontend (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .csN(csN), .loadN(loadN), .clrN(clrN),
    .code(code), .millivolts(millivolts), .updated(updated)
  );

  always @(negedge clk) begin
    if (rstN && updated) begin
      updCount++;
      runLen++;
      if (runLen > maxRun) maxRun = runLen;
    end else begin
      runLen = 0;
    end
  end

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not end, cycles %0d expected <= %0d", cycles, WATCHDOG);
      finishRun();
    end
  end

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, actual, expected);
    end
  endtask

  task automatic waitCycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sendBits(logic [31:0] value, int nbits, logic selected);
    @(negedge clk);
    csN = ~selected;
    waitCycles(HALF);
    for (int i = nbits - 1; i >= 0; i--) begin
      serData = value[i];
      serClk = 1'b0;
      waitCycles(HALF);
      serClk = 1'b1;
      waitCycles(HALF);
    end
    csN = 1'b1;
    waitCycles(HALF);
  endtask

  task automatic pulseLoad();
    loadN = 1'b0;
    waitCycles(HALF);
    loadN = 1'b1;
    waitCycles(8);
  endtask

  task automatic testReset();
    waitCycles(2);
    check("R1 code", code, 0);
    check("R1 millivolts", millivolts, 0);
    check("R1 updated", updated, 0);
  endtask

  task automatic testPreloadAndLoad();
    updCount = 0;
    sendBits(32'hA5C, 12, 1'b1);
    check("R2 code held while shifting", code, 0);
    check("R2 no update while shifting", updCount, 0);
    pulseLoad();
    check("R3 loaded code", code, 12'hA5C);
    check("R8 one update per change", updCount, 1);
  endtask

  task automatic testMidScale();
    sendBits(32'h7FF, 12, 1'b1);
    pulseLoad();
    check("R7 code 0x7FF", code, 12'h7FF);
    check("R7 millivolts 2047", millivolts, 2047);
  endtask

  task automatic testLongFrame();
    sendBits(32'hBEEF, 16, 1'b1);
    pulseLoad();
    check("R5 last 12 bits kept", code, 12'hEEF);
  endtask

  task automatic testDeselected();
    sendBits(32'h123, 12, 1'b1);
    pulseLoad();
    check("R3 loaded 0x123", code, 12'h123);
    updCount = 0;
    sendBits(32'hFFF, 12, 1'b0);
    pulseLoad();
    check("R4 deselected edges ignored", code, 12'h123);
    check("R8 no update on same value", updCount, 0);
  endtask

  task automatic testClear();
    updCount = 0;
    clrN = 1'b0;
    waitCycles(8);
    check("R6 clear forces zero", code, 0);
    check("R8 update on clear", updCount, 1);
    sendBits(32'h456, 12, 1'b1);
    pulseLoad();
    check("R6 load blocked by clear", code, 0);
    clrN = 1'b1;
    waitCycles(8);
    check("R6 zero after clear released", code, 0);
    pulseLoad();
    check("R6 input register kept through clear", code, 12'h456);
  endtask

  task automatic testFullScale();
    sendBits(32'hFFF, 12, 1'b1);
    pulseLoad();
    check("R7 millivolts 4095", millivolts, 4095);
    check("R8 update pulse one cycle wide", maxRun, 1);
  endtask

  initial begin
    waitCycles(4);
    rstN = 1'b1;
    testReset();
    testPreloadAndLoad();
    testMidScale();
    testLongFrame();
    testDeselected();
    testClear();
    testFullScale();
    finishRun();
  end
endmodule